// File: doc/BRIEF.md
# Enable-Strobed SRAM Cycle Sequencer

This block sits between a simple on-chip requester and an asynchronous static RAM that latches its address on the falling edge of an active-low chip enable. The requester presents an address, write data and a read/write flag under a valid/ready handshake. The sequencer then produces the chip-enable and write-enable strobes, drives the address and the write data, and captures the read data. Every timing minimum of the memory is a parameter expressed in system clock cycles. The integrator derives each one by rounding the nanosecond figure up against the clock period.

A cycle has three phases. In address setup the address is driven while chip enable is still high. In the strobe phase chip enable is low. The address is held for the hold window and then released, and during a write the write strobe is low. Precharge follows, with chip enable high. A new request is accepted only when the sequencer is idle and the precharge and total cycle time can no longer be violated. A read answers with a single-cycle response pulse carrying the captured data.

Top module: `strobe_ram_seq`

## Requirements
- R1: During and right after reset, chip enable and write enable are high (inactive), the address and data drives are off, no response is pending and the request port is ready.
- R2: The address is driven and unchanged for at least AS_CYC cycles before chip enable falls. It stays driven and unchanged for exactly AH_CYC cycles starting with the first low cycle, and is then released (drive off, address output zero).
- R3: In a read, chip enable stays low for exactly max(EL_CYC, ACC_CYC+1) cycles, and write enable stays high throughout.
- R4: Read data is sampled at the clock edge that ends the last low cycle of chip enable. It is returned with rsp_valid high for exactly one cycle, the first cycle in which chip enable is high again.
- R5: In a write, write enable falls together with chip enable and stays low for exactly WE_LEN = max(WP_CYC, WH_CYC, DS_CYC, 1) cycles. Chip enable stays low for exactly max(EL_CYC, WE_LEN+1, WS_CYC) cycles. Write enable is never low while chip enable is high.
- R6: The data bus is driven only in cycles where write enable is low. It is never driven during reads and is released at least one cycle before chip enable rises. The driven value is the write data of the accepted request, which the memory stores.
- R7: Between two cycles, chip enable stays high for at least EH_CYC cycles.
- R8: Successive chip-enable falling edges are at least CYC_CYC cycles apart. With a request already waiting when chip enable rises, they are exactly max(CYC_CYC, LOW+EH_CYC, LOW+1+AS_CYC) cycles apart, where LOW is the low time of the earlier cycle.
- R9: Each handshake starts exactly one memory cycle. req_ready is low from acceptance until the cycle has finished and its precharge and cycle-time limits are met.
- R10: Address, data and direction are taken at acceptance. Changes on the request inputs while a cycle runs have no effect on the memory side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read data |
| ram_ce_n | output | 1 | Chip enable, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_addr | output | ADDR_W | Address to the memory, zero when released |
| ram_addr_oe | output | 1 | Address drive enable |
| ram_dq_out | output | DATA_W | Data to the memory, zero when not driven |
| ram_dq_oe | output | 1 | Data drive enable |
| ram_dq_in | input | DATA_W | Data from the memory |

## Verification
Two things share one clock edge: the capture of read data and the rise of chip enable. The same edge also ends one cycle, while the precharge and cycle-time counters govern when a waiting request is admitted. The memory model in the bench presents a wrong pattern until the access time has elapsed, and a fixed pattern once chip enable is high. A capture one cycle early or late therefore returns data the scoreboard rejects. Back-to-back requests are kept waiting at every rise so that the next falling edge must land on the exact computed cycle. An idle gap case checks only the lower bounds.

// File: rtl/strobe_ram_seq_pkg.sv
// Shared types and constant helpers for the enable-strobed RAM sequencer.
package strobe_ram_seq_pkg;

    // Phase of the memory cycle seen on the strobes.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2
    } phase_t;

    // Larger of two integers, for parameter derivation.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/strobe_ram_seq_since.sv
// Saturating "cycles since event" counter.
// Assumes: restart is asserted in the cycle whose closing edge is the event;
// the count reads 0 in the first cycle after the event and saturates at LIMIT.
// After reset it reads LIMIT, so the event counts as long past.
module strobe_ram_seq_since #(
    parameter int LIMIT = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             restart,
    output logic [$clog2(LIMIT + 1) - 1 : 0] count
);
    localparam int W = $clog2(LIMIT + 1);

    // Count elapsed cycles, clearing on the event and saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= W'(LIMIT);
        end else if (restart) begin
            count <= '0;
        end else if (count < W'(LIMIT)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/strobe_ram_seq_ctrl.sv
// Phase controller: sequences address setup, the chip-enable low window and
// the write strobe, all in clock-cycle units.
// Assumes: is_write is stable from the accepting edge to the end of the cycle;
// AH_CYC does not exceed the chip-enable low time.
module strobe_ram_seq_ctrl
    import strobe_ram_seq_pkg::*;
#(
    parameter int AS_CYC  = 1,
    parameter int AH_CYC  = 8,
    parameter int EL_CYC  = 24,
    parameter int ACC_CYC = 24,
    parameter int WP_CYC  = 24,
    parameter int DS_CYC  = 10,
    parameter int WS_CYC  = 24,
    parameter int WH_CYC  = 24
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   is_write,
    output phase_t phase,
    output logic   go_low,
    output logic   go_high,
    output logic   capture,
    output logic   ce_n,
    output logic   we_n,
    output logic   dq_oe,
    output logic   addr_oe
);
    localparam int RD_LOW  = max2(EL_CYC, ACC_CYC + 1);
    localparam int WE_LEN  = max2(max2(WP_CYC, WH_CYC), max2(DS_CYC, 1));
    localparam int WR_LOW  = max2(max2(EL_CYC, WE_LEN + 1), WS_CYC);
    localparam int CNT_MAX = max2(max2(RD_LOW, WR_LOW), max2(AS_CYC, AH_CYC));
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int AS_LAST = (AS_CYC > 0) ? AS_CYC - 1 : 0;

    phase_t        phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] low_last;
    logic          we_win;

    assign low_last = is_write ? CW'(WR_LOW - 1) : CW'(RD_LOW - 1);

    // Transition strobes for the chip-enable edges.
    always_comb begin
        go_low  = 1'b0;
        go_high = 1'b0;
        if (phase_q == PH_IDLE && start && AS_CYC == 0) go_low = 1'b1;
        if (phase_q == PH_SETUP && cnt_q == CW'(AS_LAST)) go_low = 1'b1;
        if (phase_q == PH_LOW && cnt_q == low_last) go_high = 1'b1;
    end

    // Phase register and the in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start) phase_q <= (AS_CYC == 0) ? PH_LOW : PH_SETUP;
                end
                PH_SETUP: begin
                    if (go_low) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (go_high) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Strobe decode from the registered phase and count.
    assign we_win  = (phase_q == PH_LOW) && is_write && (cnt_q < CW'(WE_LEN));
    assign ce_n    = (phase_q != PH_LOW);
    assign we_n    = !we_win;
    assign dq_oe   = we_win;
    assign addr_oe = (phase_q == PH_SETUP) ||
                     ((phase_q == PH_LOW) && (cnt_q < CW'(AH_CYC)));
    assign capture = go_high && !is_write;
    assign phase   = phase_q;
endmodule

// File: rtl/strobe_ram_seq_dp.sv
// Datapath: request registers taken at acceptance, gated address and data
// drives, and the read capture with its one-cycle response strobe.
// Assumes: capture is asserted only at the edge that ends a read's low window.
module strobe_ram_seq_dp #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic              addr_oe,
    input  logic              dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic              is_write,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;

    // Hold the accepted request for the whole memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
        end
    end

    // Sample read data and raise the response for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= ram_dq_in;
        end
    end

    assign is_write   = write_q;
    assign ram_addr   = addr_oe ? addr_q : '0;
    assign ram_dq_out = dq_oe ? wdata_q : '0;
endmodule

// File: rtl/strobe_ram_seq.sv
// Top of the enable-strobed RAM cycle sequencer.
// Turns valid/ready requests into chip-enable, write-enable, address and data
// drives for an address-latching static RAM. Every timing minimum is given in
// clock cycles. Assumes the memory's data input is synchronous to clk.
module strobe_ram_seq
    import strobe_ram_seq_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 4,
    parameter int AS_CYC  = 1,
    parameter int AH_CYC  = 8,
    parameter int EL_CYC  = 24,
    parameter int EH_CYC  = 10,
    parameter int CYC_CYC = 34,
    parameter int ACC_CYC = 24,
    parameter int WP_CYC  = 24,
    parameter int DS_CYC  = 10,
    parameter int WS_CYC  = 24,
    parameter int WH_CYC  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ram_ce_n,
    output logic              ram_we_n,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_addr_oe,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);
    // Earliest accept, counted from the last fall (index 0) and the last rise (index 1).
    localparam int FALL_MIN = max2(CYC_CYC - 1 - AS_CYC, 0);
    localparam int RISE_MIN = max2(EH_CYC - 1 - AS_CYC, 0);
    localparam int LIMIT    = max2(max2(FALL_MIN, RISE_MIN), 1);
    localparam int TW       = $clog2(LIMIT + 1);

    phase_t        phase;
    logic          go_low;
    logic          go_high;
    logic          capture;
    logic          is_write;
    logic          start;
    logic [TW-1:0] since_q [2];
    logic          gap_ok  [2];

    // One pacing counter per chip-enable edge.
    for (genvar g = 0; g < 2; g++) begin : g_pace
        localparam int MIN_G = (g == 0) ? FALL_MIN : RISE_MIN;
        logic restart_g;
        assign restart_g = (g == 0) ? go_low : go_high;
        strobe_ram_seq_since #(.LIMIT(LIMIT)) u_since (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart_g),
            .count   (since_q[g])
        );
        assign gap_ok[g] = (since_q[g] >= TW'(MIN_G));
    end

    assign req_ready = (phase == PH_IDLE) && gap_ok[0] && gap_ok[1];
    assign start     = req_valid && req_ready;

    strobe_ram_seq_ctrl #(
        .AS_CYC  (AS_CYC),
        .AH_CYC  (AH_CYC),
        .EL_CYC  (EL_CYC),
        .ACC_CYC (ACC_CYC),
        .WP_CYC  (WP_CYC),
        .DS_CYC  (DS_CYC),
        .WS_CYC  (WS_CYC),
        .WH_CYC  (WH_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_write (is_write),
        .phase    (phase),
        .go_low   (go_low),
        .go_high  (go_high),
        .capture  (capture),
        .ce_n     (ram_ce_n),
        .we_n     (ram_we_n),
        .dq_oe    (ram_dq_oe),
        .addr_oe  (ram_addr_oe)
    );

    strobe_ram_seq_dp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .capture    (capture),
        .addr_oe    (ram_addr_oe),
        .dq_oe      (ram_dq_oe),
        .ram_dq_in  (ram_dq_in),
        .is_write   (is_write),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .ram_addr   (ram_addr),
        .ram_dq_out (ram_dq_out)
    );
endmodule

// File: rtl/strobe_ram_seq_chk.sv
// Port-level protocol checker for strobe_ram_seq, attached by bind.
// Assumes the parameters match those of the bound instance.
module strobe_ram_seq_chk #(
    parameter int ADDR_W  = 10,
    parameter int EH_CYC  = 10,
    parameter int CYC_CYC = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              ram_ce_n,
    input logic              ram_we_n,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_addr_oe,
    input logic              ram_dq_oe
);
    logic [15:0] high_run;
    logic [15:0] fall_gap;

    // Track high time and cycles since the last fall, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_run <= 16'hFFFF;
            fall_gap <= 16'hFFFF;
        end else begin
            if (!ram_ce_n) high_run <= '0;
            else if (high_run != 16'hFFFF) high_run <= high_run + 1'b1;
            if ($fell(ram_ce_n)) fall_gap <= 16'd1;
            else if (fall_gap != 16'hFFFF) fall_gap <= fall_gap + 1'b1;
        end
    end

    p_we_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> !ram_ce_n);
    p_drive_only_we_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> !ram_we_n);
    p_release_before_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_ce_n) |-> !$past(ram_dq_oe));
    p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_rsp_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(ram_ce_n));
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce_n |-> !req_ready);
    p_addr_held_at_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_ce_n) |-> (ram_addr_oe && $stable(ram_addr)));
    p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_ce_n) |-> (high_run >= 16'(EH_CYC)));
    p_cycle_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_ce_n) |-> (fall_gap >= 16'(CYC_CYC)));
endmodule

bind strobe_ram_seq strobe_ram_seq_chk #(
    .ADDR_W  (ADDR_W),
    .EH_CYC  (EH_CYC),
    .CYC_CYC (CYC_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .ram_ce_n    (ram_ce_n),
    .ram_we_n    (ram_we_n),
    .ram_addr    (ram_addr),
    .ram_addr_oe (ram_addr_oe),
    .ram_dq_oe   (ram_dq_oe)
);

// File: tb/strobe_ram_seq_test.sv
// Scoreboard bench: the driver queues expected operations and read data,
// a negedge monitor checks strobes against a cycle-level memory model.
module strobe_ram_seq_test;
    localparam int AW = 10, DW = 4;
    localparam int AS = 1, AH = 8, EL = 24, EH = 10, CYC = 34;
    localparam int ACC = 24, WP = 24, DS = 10, WS = 24, WH = 24;
    localparam int RD_LOW = (EL > ACC + 1) ? EL : ACC + 1;
    localparam int WE_A   = (WP > WH) ? WP : WH;
    localparam int WE_LEN = (WE_A > DS) ? WE_A : DS;
    localparam int WR_A   = (EL > WE_LEN + 1) ? EL : WE_LEN + 1;
    localparam int WR_LOW = (WR_A > WS) ? WR_A : WS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, ram_ce_n, ram_we_n, ram_addr_oe, ram_dq_oe;
    logic [DW-1:0] rsp_rdata, ram_dq_out;
    logic [DW-1:0] ram_dq_in = '0;
    logic [AW-1:0] ram_addr;

    always #2.5 clk = ~clk;

    strobe_ram_seq #(
        .ADDR_W(AW), .DATA_W(DW), .AS_CYC(AS), .AH_CYC(AH), .EL_CYC(EL),
        .EH_CYC(EH), .CYC_CYC(CYC), .ACC_CYC(ACC), .WP_CYC(WP),
        .DS_CYC(DS), .WS_CYC(WS), .WH_CYC(WH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_ce_n(ram_ce_n),
        .ram_we_n(ram_we_n), .ram_addr(ram_addr), .ram_addr_oe(ram_addr_oe),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    typedef struct { bit w; logic [AW-1:0] a; logic [DW-1:0] d; } op_t;
    op_t           op_q[$];
    logic [DW-1:0] rd_q[$];
    logic [DW-1:0] mem    [1024];
    logic [DW-1:0] shadow [1024];
    int checks = 0, fails = 0, issued = 0, falls = 0;
    bit done = 1'b0;

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(a) ^ DW'(a >> 6) ^ 4'h5;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory model: latch address at fall, slow data until access time, store at write end.
    int lowk = 0;
    logic [AW-1:0] lat = '0;
    logic [DW-1:0] wbuf = '0;
    logic prev_we = 1'b1;
    always @(negedge clk) begin
        if (!ram_ce_n) begin
            if (lowk == 0) lat = ram_addr;
            ram_dq_in = (lowk >= ACC) ? mem[lat] : ~mem[lat];
            if (!ram_we_n && ram_dq_oe) wbuf = ram_dq_out;
            if (!prev_we && ram_we_n) mem[lat] = wbuf;
            lowk++;
        end else begin
            lowk = 0;
            ram_dq_in = 4'hA;
        end
        prev_we = ram_we_n;
    end

    // Monitor: timing windows, addresses and read responses.
    bit prev_ce = 1'b1, prev_rsp = 1'b0, have_fall = 1'b0, b2b = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    int low_len = 0, high_len = 0, since_fall = 0, we_len = 0;
    int hold_run = 0, setup_run = 0, dsrun = 0;
    bit oe_bad = 1'b0, busy_ready = 1'b0;
    op_t cur;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ram_ce_n && prev_ce) begin
                falls++;
                if (op_q.size() == 0) begin
                    check(1'b0, "R9 unexpected cycle", falls, issued);
                end else begin
                    cur = op_q.pop_front();
                    check(ram_addr == cur.a, "R10 address", int'(ram_addr), int'(cur.a));
                end
                check(setup_run >= AS, "R2 setup", setup_run, AS);
                if (have_fall) begin
                    check(high_len >= EH, "R7 precharge", high_len, EH);
                    if (b2b) check(since_fall == 35, "R8 back-to-back period", since_fall, 35);
                    else     check(since_fall >= CYC, "R8 period", since_fall, CYC);
                end
                have_fall = 1'b1; since_fall = 0; low_len = 0; we_len = 0;
                hold_run = 0; oe_bad = 1'b0; busy_ready = 1'b0; dsrun = 0;
            end
            if (ram_ce_n && !prev_ce) begin
                if (cur.w) begin
                    check(low_len == WR_LOW, "R5 write ce low", low_len, WR_LOW);
                    check(we_len == WE_LEN, "R5 we low", we_len, WE_LEN);
                    check(dsrun >= DS, "R6 data setup", dsrun, DS);
                end else begin
                    check(low_len == RD_LOW, "R3 read ce low", low_len, RD_LOW);
                    check(we_len == 0, "R3 we high in read", we_len, 0);
                end
                check(hold_run == AH, "R2 hold", hold_run, AH);
                check(!oe_bad, "R6 drive window", int'(oe_bad), 0);
                check(!busy_ready, "R9 ready while busy", int'(busy_ready), 0);
                b2b = req_valid;
                high_len = 0;
            end
            since_fall++;
            if (!ram_ce_n) begin
                low_len++;
                if (ram_addr_oe && ram_addr == cur.a && hold_run == low_len - 1) hold_run++;
                if (!ram_we_n) we_len++;
                if (ram_dq_oe && ram_dq_out == cur.d) dsrun++;
                if (ram_dq_oe != !ram_we_n) oe_bad = 1'b1;
                if (req_ready) busy_ready = 1'b1;
            end else begin
                high_len++;
                if (ram_we_n == 1'b0 || ram_dq_oe) oe_bad = 1'b1;
                if (ram_addr_oe && ram_addr == prev_addr) setup_run++;
                else setup_run = ram_addr_oe ? 1 : 0;
            end
            if (rsp_valid) begin
                check(!prev_ce && ram_ce_n, "R4 response at rise", int'(ram_ce_n), 1);
                check(!prev_rsp, "R4 single pulse", int'(prev_rsp), 0);
                if (rd_q.size() == 0) check(1'b0, "R4 unexpected response", 1, 0);
                else begin
                    logic [DW-1:0] e;
                    e = rd_q.pop_front();
                    check(rsp_rdata == e, "R4 read data", int'(rsp_rdata), int'(e));
                end
            end
            prev_ce = ram_ce_n; prev_addr = ram_addr; prev_rsp = rsp_valid;
        end
    end

    // Driver: queue expectations, hold valid until accepted, then scramble inputs.
    task automatic do_op(input bit w, input int a, input logic [DW-1:0] d);
        op_t o;
        o.w = w; o.a = AW'(a); o.d = w ? d : '0;
        op_q.push_back(o);
        if (w) shadow[a] = d; else rd_q.push_back(shadow[a]);
        issued++;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = ~w; req_addr = ~AW'(a); req_wdata = ~d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", issued - falls, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i] = init_val(i);
            shadow[i] = init_val(i);
        end
        repeat (3) @(negedge clk);
        check(ram_ce_n && ram_we_n && !ram_dq_oe && !ram_addr_oe, "R1 strobes in reset", 0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(ram_ce_n && ram_we_n, "R1 strobes idle", int'({ram_ce_n, ram_we_n}), 3);
        check(!ram_dq_oe && !ram_addr_oe && !rsp_valid, "R1 drives off", 1, 0);
        check(req_ready, "R1 ready", int'(req_ready), 1);
        do_op(1'b0, 5, '0);
        do_op(1'b1, 5, 4'hC);
        do_op(1'b0, 5, '0);
        do_op(1'b1, 0, 4'h3);
        do_op(1'b1, 1023, 4'hF);
        do_op(1'b0, 1023, '0);
        do_op(1'b0, 0, '0);
        repeat (80) @(negedge clk);
        do_op(1'b0, 512, '0);
        repeat (60) @(negedge clk);
        do_op(1'b1, 512, 4'h0);
        do_op(1'b0, 512, '0);
        for (int k = 0; k < 6; k++) do_op(k[0], 100 + k * 37, DW'(k * 3 + 1));
        do_op(1'b0, 137, '0);
        while (op_q.size() != 0 || rd_q.size() != 0 || !ram_ce_n) @(negedge clk);
        repeat (50) @(negedge clk);
        check(falls == issued, "R9 one cycle per request", falls, issued);
        check(req_ready, "R9 ready after drain", int'(req_ready), 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule